// File: doc/BRIEF.md
# Display Memory Write Packet Decoder

This block sits behind a serial slave receiver (two-wire or four-wire) that has already recovered whole bytes and matched the slave address. It reads the byte stream and turns it into addressed writes to an on-screen display memory organised as 16 rows by 32 columns. The memory has two areas: one holds character codes and the other holds attributes and control settings. Each write leaves the block as a single-cycle strobe carrying an area select, a row, a column and the data byte.

The address bytes carry tag bits, and these tags select one of three packet formats. In the explicit-address format, each data byte is preceded by a row byte and a column byte. In the row-sticky format, the row is sent once and is then followed by pairs of column and data bytes. In the burst format, the row and column are sent once and every later byte is data, with the address advancing by itself. The explicit-address and row-sticky formats may be mixed freely. Once a burst begins, it lasts until the transaction ends. In a burst, the trailing column slots of each row carry no data: on the character area these are columns 30 and 31, and on the attribute area only column 31. These slots are skipped silently.

A transaction boundary comes from the serial front end as a one-cycle pulse. It marks a start, a stop, or the release of the slave select. This pulse puts the decoder back to waiting for a row byte.

Top module: `osd_wr_decoder`

## Requirements
- R1: After reset, wr_en is 0, and the decoder waits for a row byte.
- R2: A row byte has bits 7:6 = 10. Bit 5 selects the area, with 0 for character codes and 1 for attribute/control. Bits 3:0 give the row, and bit 4 is ignored. While the decoder waits for a row byte, any other byte is ignored.
- R3: A column byte has bits 7:6 = 00 for the explicit and row-sticky formats, or 01 for the burst format. Bits 4:0 give the column, and bit 5 is ignored. While the decoder waits for a column byte, a byte with bits 7:6 = 10 or 11 is ignored.
- R4: In the explicit and row-sticky formats, the byte after a column byte is data. It causes exactly one write, and wr_en is high in the cycle after that byte is accepted. The write carries the latched area, row and column together with the byte.
- R5: After a data byte, a byte with bits 7:6 = 00 sets a new column and keeps the area and row (row-sticky format).
- R6: After a data byte, a byte with bits 7:6 = 10 reloads the area and row (explicit format). A column byte with bits 7:6 = 01 after that reload starts a burst.
- R7: After a data byte, a byte with bits 7:6 = 01 or 11 causes no write and changes no state.
- R8: In a burst, every accepted byte is data. After each byte the column advances by one. After column 31 the column returns to 0 and the row advances by one, wrapping from row 15 to row 0.
- R9: In a burst on the character area, bytes that fall in columns 30 and 31 cause no write.
- R10: In a burst on the attribute area, a byte in column 30 is written, and a byte in column 31 causes no write.
- R11: Once a burst has started, bytes that look like row or column bytes are written as data until xfer_restart.
- R12: An xfer_restart pulse returns the decoder to waiting for a row byte. A byte presented in the same cycle as the pulse is dropped, and no write follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | byte_in holds a received byte this cycle |
| byte_in | input | 8 | Received byte |
| xfer_restart | input | 1 | Pulse on start, stop or slave-select release |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_area | output | 1 | 0 selects the character area, 1 selects the attribute/control area |
| wr_row | output | 4 | Write row |
| wr_col | output | 5 | Write column |
| wr_data | output | 8 | Write data |

## Verification
The hardest situation to reach is the burst wrap: the address moves past column 31 of row 15 and lands on row 0, column 0. Along the way it must cross dummy slots whose position depends on the area. To get there, the stimulus opens a burst near the end of row 14 on the attribute area and streams enough bytes to wrap the whole memory once. A second, full-frame burst on the character area follows. Other sequences feed bytes that look like address bytes into a running burst, and raise xfer_restart in the same cycle as a valid byte. These show that the burst format is sticky and that a byte arriving with the restart pulse is dropped.

// File: rtl/osd_wr_pkg.sv
package osd_wr_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_WAIT_ROW,
    ST_WAIT_COL,
    ST_WAIT_DATA,
    ST_AFTER_DATA,
    ST_BURST
  } dec_state_e;

  typedef enum logic [1:0] {
    BK_OTHER,
    BK_ROW,
    BK_COL_PAIR,
    BK_COL_BURST
  } byte_kind_e;

  // Tag in bits 7:6 decides what an address byte means.
  function automatic byte_kind_e classify_byte(logic [BYTE_W-1:0] b);
    case (b[7:6])
      2'b10:   return BK_ROW;
      2'b00:   return BK_COL_PAIR;
      2'b01:   return BK_COL_BURST;
      default: return BK_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/osd_byte_class.sv
module osd_byte_class
  import osd_wr_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 5
) (
  input  logic [BYTE_W-1:0] byte_in,
  output byte_kind_e        kind,
  output logic              f_area,
  output logic [ROW_W-1:0]  f_row,
  output logic [COL_W-1:0]  f_col
);

  always_comb begin
    kind   = classify_byte(byte_in);
    f_area = byte_in[5];
    f_row  = byte_in[ROW_W-1:0];
    f_col  = byte_in[COL_W-1:0];
  end

endmodule

// File: rtl/osd_dec_fsm.sv
module osd_dec_fsm
  import osd_wr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic       xfer_restart,
  input  byte_kind_e kind,
  output logic       ev_row_load,
  output logic       ev_col_load,
  output logic       ev_data,
  output logic       in_burst
);

  dec_state_e state_q, state_d;
  logic       accept;

  assign accept   = byte_vld && !xfer_restart;
  assign in_burst = (state_q == ST_BURST);

  always_comb begin
    state_d     = state_q;
    ev_row_load = 1'b0;
    ev_col_load = 1'b0;
    ev_data     = 1'b0;
    if (xfer_restart) begin
      state_d = ST_WAIT_ROW;
    end else if (accept) begin
      unique case (state_q)
        ST_WAIT_ROW: begin
          if (kind == BK_ROW) begin
            ev_row_load = 1'b1;
            state_d     = ST_WAIT_COL;
          end
        end
        ST_WAIT_COL: begin
          if (kind == BK_COL_PAIR) begin
            ev_col_load = 1'b1;
            state_d     = ST_WAIT_DATA;
          end else if (kind == BK_COL_BURST) begin
            ev_col_load = 1'b1;
            state_d     = ST_BURST;
          end
        end
        ST_WAIT_DATA: begin
          ev_data = 1'b1;
          state_d = ST_AFTER_DATA;
        end
        ST_AFTER_DATA: begin
          if (kind == BK_ROW) begin
            ev_row_load = 1'b1;
            state_d     = ST_WAIT_COL;
          end else if (kind == BK_COL_PAIR) begin
            ev_col_load = 1'b1;
            state_d     = ST_WAIT_DATA;
          end
        end
        ST_BURST: ev_data = 1'b1;
        default:  state_d = ST_WAIT_ROW;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_WAIT_ROW;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/osd_addr_track.sv
module osd_addr_track #(
  parameter int ROW_W         = 4,
  parameter int COL_W         = 5,
  parameter int CHAR_LAST_COL = 29,
  parameter int ATTR_LAST_COL = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_row_load,
  input  logic             ev_col_load,
  input  logic             ev_data,
  input  logic             in_burst,
  input  logic             f_area,
  input  logic [ROW_W-1:0] f_row,
  input  logic [COL_W-1:0] f_col,
  output logic             cur_area,
  output logic [ROW_W-1:0] cur_row,
  output logic [COL_W-1:0] cur_col,
  output logic             ev_dummy
);

  localparam int SLOT_W = ROW_W + COL_W;
  localparam logic [COL_W-1:0] CHAR_LAST_V = COL_W'(CHAR_LAST_COL);
  localparam logic [COL_W-1:0] ATTR_LAST_V = COL_W'(ATTR_LAST_COL);

  // Slots past the last live column of the area carry no data.
  function automatic logic slot_is_dummy(logic area, logic [COL_W-1:0] c);
    return area ? (c > ATTR_LAST_V) : (c > CHAR_LAST_V);
  endfunction

  // Row-major step; the column field overflows into the row.
  function automatic logic [SLOT_W-1:0] next_slot(logic [ROW_W-1:0] r,
                                                  logic [COL_W-1:0] c);
    return {r, c} + 1'b1;
  endfunction

  logic step;

  assign step     = ev_data && in_burst;
  assign ev_dummy = step && slot_is_dummy(cur_area, cur_col);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_area <= 1'b0;
      cur_row  <= '0;
      cur_col  <= '0;
    end else begin
      if (ev_row_load) begin
        cur_area <= f_area;
        cur_row  <= f_row;
      end
      if (ev_col_load) cur_col <= f_col;
      if (step) {cur_row, cur_col} <= next_slot(cur_row, cur_col);
    end
  end

endmodule

// File: rtl/osd_wr_decoder.sv
module osd_wr_decoder
  import osd_wr_pkg::*;
#(
  parameter int ROW_W         = 4,
  parameter int COL_W         = 5,
  parameter int CHAR_LAST_COL = 29,
  parameter int ATTR_LAST_COL = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              xfer_restart,
  output logic              wr_en,
  output logic              wr_area,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [BYTE_W-1:0] wr_data
);

  byte_kind_e       kind;
  logic             f_area;
  logic [ROW_W-1:0] f_row;
  logic [COL_W-1:0] f_col;
  logic             ev_row_load, ev_col_load, ev_data, in_burst, ev_dummy;
  logic             cur_area;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;

  osd_byte_class #(.ROW_W(ROW_W), .COL_W(COL_W)) u_class (
    .byte_in (byte_in),
    .kind    (kind),
    .f_area  (f_area),
    .f_row   (f_row),
    .f_col   (f_col)
  );

  osd_dec_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_vld     (byte_vld),
    .xfer_restart (xfer_restart),
    .kind         (kind),
    .ev_row_load  (ev_row_load),
    .ev_col_load  (ev_col_load),
    .ev_data      (ev_data),
    .in_burst     (in_burst)
  );

  osd_addr_track #(
    .ROW_W(ROW_W), .COL_W(COL_W),
    .CHAR_LAST_COL(CHAR_LAST_COL), .ATTR_LAST_COL(ATTR_LAST_COL)
  ) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_row_load (ev_row_load),
    .ev_col_load (ev_col_load),
    .ev_data     (ev_data),
    .in_burst    (in_burst),
    .f_area      (f_area),
    .f_row       (f_row),
    .f_col       (f_col),
    .cur_area    (cur_area),
    .cur_row     (cur_row),
    .cur_col     (cur_col),
    .ev_dummy    (ev_dummy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_area <= 1'b0;
      wr_row  <= '0;
      wr_col  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= ev_data && !ev_dummy;
      if (ev_data) begin
        wr_area <= cur_area;
        wr_row  <= cur_row;
        wr_col  <= cur_col;
        wr_data <= byte_in;
      end
    end
  end

endmodule

// File: rtl/osd_wr_decoder_chk.sv
module osd_wr_decoder_chk #(
  parameter int COL_W         = 5,
  parameter int CHAR_LAST_COL = 29,
  parameter int ATTR_LAST_COL = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic             xfer_restart,
  input logic             wr_en,
  input logic             wr_area,
  input logic [COL_W-1:0] wr_col,
  input logic             in_burst,
  input logic             ev_dummy,
  input logic             ev_row_load,
  input logic             ev_col_load,
  input logic             ev_data
);

  assert_write_needs_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(byte_vld) && !$past(xfer_restart)));

  assert_one_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_row_load, ev_col_load, ev_data}));

  assert_dummy_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dummy |=> !wr_en);

  assert_char_burst_cols_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_area && $past(in_burst)) |-> (wr_col <= COL_W'(CHAR_LAST_COL)));

  assert_attr_burst_cols_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_area && $past(in_burst)) |-> (wr_col <= COL_W'(ATTR_LAST_COL)));

  assert_burst_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && !xfer_restart) |=> in_burst);

  assert_restart_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_restart |=> (!wr_en && !in_burst));

endmodule

bind osd_wr_decoder osd_wr_decoder_chk #(
  .COL_W(COL_W), .CHAR_LAST_COL(CHAR_LAST_COL), .ATTR_LAST_COL(ATTR_LAST_COL)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .byte_vld     (byte_vld),
  .xfer_restart (xfer_restart),
  .wr_en        (wr_en),
  .wr_area      (wr_area),
  .wr_col       (wr_col),
  .in_burst     (in_burst),
  .ev_dummy     (ev_dummy),
  .ev_row_load  (ev_row_load),
  .ev_col_load  (ev_col_load),
  .ev_data      (ev_data)
);

// File: tb/osd_wr_decoder_bench.sv
`timescale 1ns/1ps
module osd_wr_decoder_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       xfer_restart = 1'b0;
  logic       wr_en, wr_area;
  logic [3:0] wr_row;
  logic [4:0] wr_col;
  logic [7:0] wr_data;

  int    total = 0;
  int    bad = 0;
  string tag = "R1";
  bit    done = 0;

  always #2 clk = ~clk;

  osd_wr_decoder u_osd_wr_decoder (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .xfer_restart(xfer_restart), .wr_en(wr_en), .wr_area(wr_area),
    .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data)
  );

  // Behavioural reference: mode 0 wait row, 1 wait column, 2 wait data,
  // 3 after data, 4 burst.
  int mode, m_area, m_row, m_col, lim;
  int e_en, e_area, e_row, e_col, e_data;

  task automatic emit();
    e_en = 1; e_area = m_area; e_row = m_row; e_col = m_col; e_data = byte_in;
  endtask

  always @(posedge clk) begin
    int top2;
    if (!rst_n) begin
      mode = 0; m_area = 0; m_row = 0; m_col = 0; e_en = 0;
    end else begin
      e_en = 0;
      top2 = byte_in / 64;
      if (xfer_restart) mode = 0;
      else if (byte_vld) begin
        if (mode == 0 || mode == 3) begin
          if (top2 == 2) begin
            m_area = (byte_in / 32) % 2; m_row = byte_in % 16; mode = 1;
          end else if (mode == 3 && top2 == 0) begin
            m_col = byte_in % 32; mode = 2;
          end
        end else if (mode == 1) begin
          if (top2 == 0) begin m_col = byte_in % 32; mode = 2; end
          else if (top2 == 1) begin m_col = byte_in % 32; mode = 4; end
        end else if (mode == 2) begin
          emit(); mode = 3;
        end else begin
          lim = (m_area == 1) ? 30 : 29;
          if (m_col <= lim) emit();
          m_col = m_col + 1;
          if (m_col == 32) begin m_col = 0; m_row = (m_row + 1) % 16; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (wr_en !== (e_en == 1)) begin
        bad++;
        $display("FAIL %s wr_en actual=%0b expected=%0d", tag, wr_en, e_en);
      end else if (e_en == 1 && (wr_area !== e_area[0] || wr_row !== e_row[3:0] ||
                                 wr_col !== e_col[4:0] || wr_data !== e_data[7:0])) begin
        bad++;
        $display("FAIL %s write actual=a%0d r%0d c%0d d%02h expected=a%0d r%0d c%0d d%02h",
                 tag, wr_area, wr_row, wr_col, wr_data, e_area, e_row, e_col, e_data);
      end
    end
  end

  task automatic put(input logic [7:0] b, input int gap);
    @(negedge clk); byte_vld = 1'b1; byte_in = b;
    @(negedge clk); byte_vld = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic put_bb(input logic [7:0] b);
    @(negedge clk); byte_vld = 1'b1; byte_in = b;
  endtask

  task automatic pause(input int n);
    @(negedge clk); byte_vld = 1'b0; xfer_restart = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic restart_pulse(input bit with_byte, input logic [7:0] b);
    @(negedge clk); xfer_restart = 1'b1; byte_vld = with_byte; byte_in = b;
    @(negedge clk); xfer_restart = 1'b0; byte_vld = 1'b0;
  endtask

  task automatic direct_check(input string req, input bit exp_en);
    @(negedge clk);
    total++;
    if (wr_en !== exp_en) begin
      bad++;
      $display("FAIL %s direct wr_en actual=%0b expected=%0b", req, wr_en, exp_en);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (wr_en !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset wr_en actual=%0b expected=0", wr_en);
    end
    rst_n = 1'b1;
    pause(2);

    tag = "R4";  put(8'h83, 0); put(8'h05, 1); put(8'h41, 2);
    tag = "R6";  put(8'hB2, 0); put(8'h27, 0); put(8'h55, 1);
    tag = "R2";  put(8'h9C, 0); put(8'h03, 0); put(8'hE7, 1);
    tag = "R5";  put(8'h0A, 0); put(8'hAA, 0); put(8'h1F, 0); put(8'h3C, 2);
    tag = "R7";  put(8'h40, 1); put(8'hC3, 1); put(8'h7F, 1); put(8'h02, 0); put(8'h99, 1);

    tag = "R12"; restart_pulse(1'b0, 8'h00);
    tag = "R2";  put(8'h00, 0); put(8'hFF, 0); put(8'h60, 0); put(8'h11, 0);
    tag = "R3";  put(8'h81, 0); put(8'h85, 0); put(8'hC0, 0); put(8'h21, 0); put(8'h77, 1);

    tag = "R9";  restart_pulse(1'b0, 8'h00);
    put_bb(8'h81); put_bb(8'h5C);
    for (int i = 0; i < 8; i++) put_bb(8'h10 + 8'(i));
    tag = "R11"; put_bb(8'h83); put_bb(8'h05); put_bb(8'hA0); put_bb(8'h45);
    pause(2);

    tag = "R10"; restart_pulse(1'b0, 8'h00);
    put(8'hAE, 0); put(8'h7D, 0);
    for (int i = 0; i < 40; i++) put_bb(8'hC0 + 8'(i % 64));
    pause(1);

    tag = "R12"; restart_pulse(1'b1, 8'h33);
    direct_check("R12", 1'b0);
    put(8'h44, 1);
    direct_check("R12", 1'b0);

    tag = "R6";  put(8'h84, 0); put(8'h01, 0); put(8'h12, 0);
    put(8'hA7, 0); put(8'h5E, 0);
    for (int i = 0; i < 5; i++) put(8'h20 + 8'(i), i % 2);

    tag = "R8";  restart_pulse(1'b0, 8'h00);
    put(8'h80, 0); put(8'h40, 0);
    for (int i = 0; i < 16 * 32 + 3; i++) put_bb(8'(i * 7));
    pause(2);

    tag = "R12"; restart_pulse(1'b1, 8'h81);
    put(8'h01, 0); put(8'h66, 1);
    pause(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL timeout (all requirements) actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule